// File: doc/BRIEF.md
# Halfword-Select Signed Multiply-Accumulate Long

This is an execute-stage datapath for a signed 16x16 multiply that accumulates into a 64-bit register pair. It takes a 32-bit instruction word, a strobe from the condition logic, two 32-bit source operands and the current accumulator as separate high and low words. A field decoder checks whether the word is the long halfword multiply-accumulate encoding. Two instruction bits then pick the upper or lower halfword of each source on their own.

The two chosen halfwords are multiplied as signed values. The 32-bit product is sign-extended and added to the 64-bit accumulator. The sum wraps silently, and the block has no flag or overflow output. The new high and low words leave through a register stage one cycle later. They come with the destination register indices taken from the instruction and a write-enable. When the word does not decode, or the condition strobe is low, the write-enable stays low and the accumulator passes through unchanged.

Top module: `hsmacl_exec`

## Requirements
- R1: The first operand is `src_a[15:0]` when `instr[5]` is 0 and `src_a[31:16]` when `instr[5]` is 1.
- R2: The second operand is `src_b[15:0]` when `instr[6]` is 0 and `src_b[31:16]` when `instr[6]` is 1.
- R3: The unselected halfword of each source has no effect on any output.
- R4: Both operands are signed two's-complement halfwords, and their product is an exact signed 32-bit value; (-32768)x(-32768) gives 0x40000000.
- R5: The product is sign-extended to 64 bits and added to `{acc_hi, acc_lo}`. The sum wraps modulo 2^64, and no overflow or flag output exists.
- R6: `res_hi` carries bits 63:32 of the sum and `res_lo` carries bits 31:0.
- R7: The word decodes as this operation when `instr[27:20]` is 8'h14, `instr[7]` is 1 and `instr[4]` is 0. `instr[31:28]` is not examined.
- R8: `wr_en` is 1 only when the word decodes and `cond_ok` is 1. Otherwise `wr_en` is 0 and `res_hi`/`res_lo` equal `acc_hi`/`acc_lo`.
- R9: `dst_hi` equals `instr[19:16]` and `dst_lo` equals `instr[15:12]`.
- R10: Outputs appear one clock edge after the inputs. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction word |
| cond_ok | input | 1 | Condition-passed strobe |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| acc_hi | input | 32 | Accumulator upper word |
| acc_lo | input | 32 | Accumulator lower word |
| res_hi | output | 32 | New accumulator upper word |
| res_lo | output | 32 | New accumulator lower word |
| dst_hi | output | 4 | Destination index for the upper word |
| dst_lo | output | 4 | Destination index for the lower word |
| wr_en | output | 1 | Write-back enable |

## Verification
The hardest case to reach is a carry or borrow that crosses the whole 64-bit pair. It only happens when the accumulator is within one product of the wrap point, so random sources almost never produce it. The stimulus loads `{acc_hi, acc_lo}` with all ones or with 0x7FFF_FFFF_FFFF_FFFF and chooses halfwords whose product is +1, so both words roll over together. A second directed case covers the single product that needs bit 30 set: both operands at -32768. Further tests change only the unselected halves, and only one decode bit at a time, to show that neither changes the outputs beyond what the requirements allow.

// File: rtl/hsmacl_pkg.sv
package hsmacl_pkg;
  localparam int unsigned RIDX_W = 4;

  // Fixed field positions of the decoded word
  localparam int unsigned OPC_LSB   = 20;
  localparam logic [7:0]  OPC_VALUE = 8'h14;
  localparam int unsigned FIX1_BIT  = 7;
  localparam int unsigned BTOP_BIT  = 6;
  localparam int unsigned ATOP_BIT  = 5;
  localparam int unsigned FIX0_BIT  = 4;
  localparam int unsigned DHI_LSB   = 16;
  localparam int unsigned DLO_LSB   = 12;

  typedef struct packed {
    logic              hit;
    logic              a_top;
    logic              b_top;
    logic [RIDX_W-1:0] hi_idx;
    logic [RIDX_W-1:0] lo_idx;
  } hsmacl_dec_t;
endpackage

// File: rtl/hsmacl_decode.sv
module hsmacl_decode
  import hsmacl_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0] instr,
  output hsmacl_dec_t       dec
);
  logic opc_ok;
  logic fix_ok;

  assign opc_ok = (instr[OPC_LSB +: 8] == OPC_VALUE);
  assign fix_ok = instr[FIX1_BIT] & ~instr[FIX0_BIT];

  always_comb begin
    dec.hit    = opc_ok & fix_ok;
    dec.a_top  = instr[ATOP_BIT];
    dec.b_top  = instr[BTOP_BIT];
    dec.hi_idx = instr[DHI_LSB +: RIDX_W];
    dec.lo_idx = instr[DLO_LSB +: RIDX_W];
  end
endmodule

// File: rtl/hsmacl_half_sel.sv
module hsmacl_half_sel #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned HALF_W = WORD_W / 2
) (
  input  logic [WORD_W-1:0] word,
  input  logic              top,
  output logic [HALF_W-1:0] half
);
  function automatic logic [HALF_W-1:0] pick(input logic [WORD_W-1:0] w, input logic t);
    return t ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
  endfunction

  assign half = pick(word, top);
endmodule

// File: rtl/hsmacl_mac.sv
module hsmacl_mac #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned HALF_W = WORD_W / 2,
  localparam int unsigned ACC_W  = 2 * WORD_W
) (
  input  logic [HALF_W-1:0] op_a,
  input  logic [HALF_W-1:0] op_b,
  input  logic [WORD_W-1:0] acc_hi,
  input  logic [WORD_W-1:0] acc_lo,
  output logic [WORD_W-1:0] prod,
  output logic [WORD_W-1:0] sum_hi,
  output logic [WORD_W-1:0] sum_lo
);
  // Exact signed product of two halfwords fits the word width
  function automatic logic [WORD_W-1:0] smul(input logic [HALF_W-1:0] a, input logic [HALF_W-1:0] b);
    logic signed [WORD_W-1:0] ea;
    logic signed [WORD_W-1:0] eb;
    ea = {{HALF_W{a[HALF_W-1]}}, a};
    eb = {{HALF_W{b[HALF_W-1]}}, b};
    return ea * eb;
  endfunction

  // Sign-extend and add, modulo 2^ACC_W
  function automatic logic [ACC_W-1:0] accum(input logic [WORD_W-1:0] p,
                                             input logic [WORD_W-1:0] hi,
                                             input logic [WORD_W-1:0] lo);
    return {hi, lo} + {{WORD_W{p[WORD_W-1]}}, p};
  endfunction

  logic [ACC_W-1:0] sum;

  assign prod = smul(op_a, op_b);
  assign sum  = accum(prod, acc_hi, acc_lo);
  assign sum_hi = sum[ACC_W-1:WORD_W];
  assign sum_lo = sum[WORD_W-1:0];
endmodule

// File: rtl/hsmacl_exec.sv
module hsmacl_exec
  import hsmacl_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] instr,
  input  logic              cond_ok,
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  input  logic [WORD_W-1:0] acc_hi,
  input  logic [WORD_W-1:0] acc_lo,
  output logic [WORD_W-1:0] res_hi,
  output logic [WORD_W-1:0] res_lo,
  output logic [RIDX_W-1:0] dst_hi,
  output logic [RIDX_W-1:0] dst_lo,
  output logic              wr_en
);
  hsmacl_dec_t dec;

  // Named internal events, visible to the checker
  logic              dec_hit;
  logic              commit;
  logic [WORD_W-1:0] mul_prod;
  logic [WORD_W-1:0] sum_hi;
  logic [WORD_W-1:0] sum_lo;

  logic [WORD_W-1:0] srcs [2];
  logic              tops [2];
  logic [HALF_W-1:0] halves [2];

  hsmacl_decode #(.WORD_W(WORD_W)) dec_i (.instr(instr), .dec(dec));

  assign dec_hit = dec.hit;
  assign commit  = dec_hit & cond_ok;

  assign srcs[0] = src_a;
  assign srcs[1] = src_b;
  assign tops[0] = dec.a_top;
  assign tops[1] = dec.b_top;

  for (genvar s = 0; s < 2; s++) begin : g_sel
    hsmacl_half_sel #(.WORD_W(WORD_W)) sel_i (
      .word(srcs[s]),
      .top (tops[s]),
      .half(halves[s])
    );
  end

  hsmacl_mac #(.WORD_W(WORD_W)) mac_i (
    .op_a  (halves[0]),
    .op_b  (halves[1]),
    .acc_hi(acc_hi),
    .acc_lo(acc_lo),
    .prod  (mul_prod),
    .sum_hi(sum_hi),
    .sum_lo(sum_lo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_hi <= '0;
      res_lo <= '0;
      dst_hi <= '0;
      dst_lo <= '0;
      wr_en  <= 1'b0;
    end else begin
      res_hi <= commit ? sum_hi : acc_hi;
      res_lo <= commit ? sum_lo : acc_lo;
      dst_hi <= dec.hi_idx;
      dst_lo <= dec.lo_idx;
      wr_en  <= commit;
    end
  end
endmodule

// File: rtl/hsmacl_exec_chk.sv
module hsmacl_exec_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned RIDX_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] instr,
  input logic              cond_ok,
  input logic [WORD_W-1:0] acc_hi,
  input logic [WORD_W-1:0] acc_lo,
  input logic [WORD_W-1:0] res_hi,
  input logic [WORD_W-1:0] res_lo,
  input logic [RIDX_W-1:0] dst_hi,
  input logic [RIDX_W-1:0] dst_lo,
  input logic              wr_en,
  input logic              dec_hit,
  input logic [WORD_W-1:0] mul_prod
);
  // R4: only (-32768)x(-32768) reaches the top positive bit
  a_r4_prod_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_prod[WORD_W-1] != mul_prod[WORD_W-2]) |-> (mul_prod == {2'b01, {(WORD_W-2){1'b0}}}));

  // R5: written result minus old accumulator is the sign-extended product
  a_r5_delta: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (({res_hi, res_lo} - $past({acc_hi, acc_lo})) ==
               {{WORD_W{$past(mul_prod[WORD_W-1])}}, $past(mul_prod)}));

  // R8: decoded and passed leads to a write one edge later
  a_r8_commit_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_hit && cond_ok) |=> wr_en);

  // R8: otherwise the accumulator passes through with no write
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_hit && cond_ok) |=> (!wr_en && res_hi == $past(acc_hi) && res_lo == $past(acc_lo)));

  // R9: destination indices travel with the write
  a_r9_dst: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (dst_hi == $past(instr[19:16]) && dst_lo == $past(instr[15:12])));

  // R10: first cycle out of reset still shows cleared outputs
  a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!wr_en && res_hi == '0 && res_lo == '0));
endmodule

bind hsmacl_exec hsmacl_exec_chk #(.WORD_W(WORD_W), .RIDX_W(hsmacl_pkg::RIDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .instr(instr), .cond_ok(cond_ok),
  .acc_hi(acc_hi), .acc_lo(acc_lo), .res_hi(res_hi), .res_lo(res_lo),
  .dst_hi(dst_hi), .dst_lo(dst_lo), .wr_en(wr_en),
  .dec_hit(dec_hit), .mul_prod(mul_prod)
);

// File: tb/hsmacl_exec_tb_top.sv
module hsmacl_exec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic        cond_ok = 1'b0;
  logic [31:0] src_a = '0, src_b = '0, acc_hi = '0, acc_lo = '0;
  logic [31:0] res_hi, res_lo;
  logic [3:0]  dst_hi, dst_lo;
  logic        wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsmacl_exec dut_i (
    .clk(clk), .rst_n(rst_n), .instr(instr), .cond_ok(cond_ok),
    .src_a(src_a), .src_b(src_b), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .res_hi(res_hi), .res_lo(res_lo), .dst_hi(dst_hi), .dst_lo(dst_lo), .wr_en(wr_en)
  );

  // Build a matching word: a_top -> bit 5, b_top -> bit 6
  function automatic logic [31:0] enc(input logic [3:0] cnd, input logic [3:0] dh, input logic [3:0] dl,
                                      input logic [3:0] rb, input logic bt, input logic at, input logic [3:0] ra);
    return {cnd, 8'h14, dh, dl, rb, 1'b1, bt, at, 1'b0, ra};
  endfunction

  // Independent model using 64-bit integer multiply
  function automatic logic [63:0] model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] hi, input logic [31:0] lo);
    logic signed [15:0] x;
    logic signed [15:0] y;
    longint p;
    x = ins[5] ? a[31:16] : a[15:0];
    y = ins[6] ? b[31:16] : b[15:0];
    p = longint'(x) * longint'(y);
    return {hi, lo} + 64'(p);
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step(input logic [31:0] i, input logic c, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] h, input logic [31:0] l);
    @(negedge clk);
    instr = i; cond_ok = c; src_a = a; src_b = b; acc_hi = h; acc_lo = l;
    @(negedge clk);
  endtask

  task automatic exp_write(input string tag, input logic [31:0] i, input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] h, input logic [31:0] l);
    step(i, 1'b1, a, b, h, l);
    chk({tag, " result"}, {res_hi, res_lo}, model(i, a, b, h, l));
    chk({tag, " wr_en"}, 64'(wr_en), 64'd1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    instr = enc(4'he, 4'h3, 4'h2, 4'h1, 1'b1, 1'b0, 4'h0);
    cond_ok = 1'b1; src_a = 32'h5; src_b = 32'h70000; acc_lo = 32'h9;
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {res_hi, res_lo}, 64'd0);
    chk("R10 reset wr_en/dst", {55'd0, wr_en, dst_hi, dst_lo}, 64'd0);
    instr = '0; cond_ok = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic t_selects;
    logic [31:0] a = 32'hFFFD_0007;
    logic [31:0] b = 32'h0005_FFFE;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] i = enc(4'hE, 4'h1, 4'h0, 4'h2, k[1], k[0], 4'h3);
      exp_write($sformatf("R1 R2 R6 select %0d", k), i, a, b, 32'h0000_0001, 32'h0000_0100);
    end
    // Explicit value: bottom(a)=7 x top(b)=5 = 35 on top of 0
    step(enc(4'hE, 4'h1, 4'h0, 4'h2, 1'b1, 1'b0, 4'h3), 1'b1, a, b, 32'h0, 32'h0);
    chk("R1 R2 bottom x top value", {res_hi, res_lo}, 64'd35);
  endtask

  task automatic t_ignore_other;
    logic [31:0] i = enc(4'hE, 4'h4, 4'h5, 4'h6, 1'b1, 1'b0, 4'h7);
    logic [63:0] first;
    step(i, 1'b1, 32'h0000_1234, 32'hFEDC_0000, 32'h11, 32'h22);
    first = {res_hi, res_lo};
    step(i, 1'b1, 32'hABCD_1234, 32'hFEDC_9876, 32'h11, 32'h22);
    chk("R3 unselected halves ignored", {res_hi, res_lo}, first);
    chk("R3 value", first, model(i, 32'h1234, 32'hFEDC_0000, 32'h11, 32'h22));
  endtask

  task automatic t_signed;
    logic [31:0] i = enc(4'hE, 4'h1, 4'h0, 4'h2, 1'b0, 1'b0, 4'h3);
    step(i, 1'b1, 32'h0000_8000, 32'h0000_8000, 32'h0, 32'h0);
    chk("R4 min x min", {res_hi, res_lo}, 64'h0000_0000_4000_0000);
    step(i, 1'b1, 32'h0000_8000, 32'h0000_7FFF, 32'h0, 32'h0);
    chk("R4 min x max", {res_hi, res_lo}, 64'hFFFF_FFFF_C000_8000);
    exp_write("R4 neg x neg", i, 32'h0000_FFFF, 32'h0000_FFFE, 32'h3, 32'h4);
  endtask

  task automatic t_wrap;
    logic [31:0] i = enc(4'hE, 4'h1, 4'h0, 4'h2, 1'b0, 1'b0, 4'h3);
    step(i, 1'b1, 32'h1, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R5 wrap to zero", {res_hi, res_lo}, 64'd0);
    step(i, 1'b1, 32'h1, 32'h1, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    chk("R5 signed overflow wraps", {res_hi, res_lo}, 64'h8000_0000_0000_0000);
    step(i, 1'b1, 32'hFFFF, 32'h1, 32'h0000_0001, 32'h0000_0000);
    chk("R5 R6 borrow into hi", {res_hi, res_lo}, 64'h0000_0000_FFFF_FFFF);
  endtask

  task automatic t_cond;
    logic [31:0] i = enc(4'hE, 4'h9, 4'h8, 4'h2, 1'b1, 1'b0, 4'h3);
    step(i, 1'b0, 32'h0000_0003, 32'h0004_0000, 32'hCAFE_0000, 32'h0000_BEEF);
    chk("R8 cond low holds acc", {res_hi, res_lo}, 64'hCAFE_0000_0000_BEEF);
    chk("R8 cond low wr_en", 64'(wr_en), 64'd0);
    for (int c = 0; c < 16; c += 5) begin
      logic [31:0] j = enc(c[3:0], 4'h9, 4'h8, 4'h2, 1'b1, 1'b0, 4'h3);
      exp_write($sformatf("R7 cond field %0d", c), j, 32'h3, 32'h0004_0000, 32'h0, 32'h10);
    end
  endtask

  task automatic t_decode;
    logic [31:0] good = enc(4'hE, 4'h9, 4'h8, 4'h2, 1'b1, 1'b0, 4'h3);
    logic [31:0] bad [4];
    bad[0] = good | 32'h0000_0010;   // bit 4 set
    bad[1] = good & ~32'h0000_0080;  // bit 7 clear
    bad[2] = good | 32'h0010_0000;   // bit 20 set
    bad[3] = good ^ 32'h0800_0000;   // bit 27 set
    for (int k = 0; k < 4; k++) begin
      step(bad[k], 1'b1, 32'h3, 32'h0004_0000, 32'h1234_5678, 32'h9ABC_DEF0);
      chk($sformatf("R7 R8 bad word %0d result", k), {res_hi, res_lo}, 64'h1234_5678_9ABC_DEF0);
      chk($sformatf("R7 R8 bad word %0d wr_en", k), 64'(wr_en), 64'd0);
    end
  endtask

  task automatic t_dst_latency;
    logic [31:0] i = enc(4'hE, 4'hA, 4'h5, 4'h2, 1'b0, 1'b0, 4'h3);
    step(i, 1'b1, 32'h2, 32'h3, 32'h0, 32'h0);
    chk("R9 dst indices", {56'd0, dst_hi, dst_lo}, 64'hA5);
    @(negedge clk);
    instr = enc(4'hE, 4'h3, 4'hC, 4'h2, 1'b0, 1'b0, 4'h3);
    src_a = 32'h4;
    #1;
    chk("R10 no change before edge", {res_hi, res_lo}, 64'd6);
    @(negedge clk);
    chk("R10 change after one edge", {res_hi, res_lo}, 64'd12);
    chk("R9 dst after edge", {56'd0, dst_hi, dst_lo}, 64'h3C);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_selects();
    t_ignore_other();
    t_signed();
    t_wrap();
    t_cond();
    t_decode();
    t_dst_latency();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule